// File: doc/BRIEF.md
# Continuous Full-Duplex Framed Serial Exchanger

This block is the controller end of a point-to-point serial link to a line transceiver. It makes a bit clock from the system clock and a frame clock that marks frame boundaries. Each frame moves one 16-bit word out on one wire while another 16-bit word comes in on a second wire. Frames follow each other with no gap, so a word is always in flight in both directions. Every frame, in either direction, holds an 8-bit status field and then an 8-bit data field, and bits go most significant first.

On the parallel side, the host places a status byte and a data byte on two input buses. They are captured when a frame begins. On the receive side, each finished frame is split into a status byte and a data byte. Both are held steady on the outputs, and a strobe one system cycle wide marks each new pair. The whole block runs in the system clock domain. The bit clock is a divided register, and all shifting happens in the system cycle in which the bit clock falls.

Top module: `duplex_frame_link`

## Requirements
- R1: While `rst` is high, `bitClk`, `frameClk`, `serOut` and `rxValid` are low, and `rxStatus` and `rxData` are zero.
- R2: After reset, `bitClk` has a period of 4 system cycles (`BIT_DIV`) and is high for 2 of them. It first rises 2 cycles after reset is released.
- R3: Frames are 16 bit periods long and follow each other without gaps. `frameClk` rises in the cycle in which `bitClk` falls to begin the 16th bit of a frame. It stays high for exactly one bit period (4 cycles), so its rising edges are 64 cycles apart.
- R4: `serOut` changes only in the cycle in which `bitClk` falls, so it is stable at every rising edge. The 16 bits of a frame are sent in this order: `txStatus[7]` down to `txStatus[0]`, then `txData[7]` down to `txData[0]`.
- R5: `txStatus` and `txData` are captured at the falling bit-clock edge that begins a frame. A write made in the middle of a frame does not change that frame; it is sent in the next frame.
- R6: `serIn` is sampled at each falling edge of `bitClk`. The bit sampled at the falling edge of `frameClk` is the first bit (MSB) of an incoming frame. Of the 16 incoming bits, the first 8 go to `rxStatus` (first bit in bit 7) and the last 8 go to `rxData` (last bit in bit 0).
- R7: `rxValid` goes high for exactly one system cycle after the last bit of each incoming frame is sampled. `rxStatus` and `rxData` change only in a cycle in which `rxValid` is high and otherwise hold their values.
- R8: After reset, `serOut` stays low until the first falling edge of `bitClk`. At that edge the first frame starts with the MSB of the captured `txStatus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txStatus | input | 8 | Status byte for the next outgoing frame |
| txData | input | 8 | Data byte for the next outgoing frame |
| serIn | input | 1 | Serial line from the transceiver |
| bitClk | output | 1 | Bit clock, system clock divided by 4 |
| frameClk | output | 1 | High during the last bit period of each frame |
| serOut | output | 1 | Serial line to the transceiver |
| rxStatus | output | 8 | Status byte of the last frame received |
| rxData | output | 8 | Data byte of the last frame received |
| rxValid | output | 1 | One-cycle strobe marking a new received pair |

## Verification
The outgoing side is tried with all-zero and all-one words, words with only the end bits set or cleared, and alternating patterns. A bit-order or field-swap fault moves these visibly, while a stuck line or an off-by-one shift changes the end bits. Some transmit words are written during the last bit period before their frame, and others in the middle of the previous frame. This shows whether capture happens only at the frame's start. A far-end model follows the rising-edge rule and sends its own set of byte-swapped words back, so a misaligned receive frame or a swapped status/data split gives a wrong pair. Edge timing of both clocks is measured in system cycles.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

  // Strobes handed from the control to the datapath, all one system cycle wide.
  typedef struct packed {
    logic fallTick;    // bit clock falls at this edge: sample input, drive next bit
    logic frameStart;  // fallTick that drives the first bit of a frame
    logic frameEnd;    // fallTick that drives and samples the last bit of a frame
  } dflStrobe_t;

endpackage

// File: rtl/dfl_ctrl.sv
module dfl_ctrl
  import dfl_pkg::*;
#(
  parameter int BIT_DIV    = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  output logic       bitClk,
  output logic       frameClk,
  output dflStrobe_t strb
);

  localparam int DIV_W = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int HALF  = BIT_DIV / 2;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BIT_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(HALF);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divNext;
  logic [IDX_W-1:0] bitIdx;
  logic             fallNow;

  assign fallNow = (divCnt == DIV_LAST);

  always_comb begin
    if (fallNow) divNext = '0;
    else         divNext = divCnt + DIV_W'(1);
  end

  // Divider and registered bit clock: high in the upper half of the count.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      bitClk <= 1'b0;
    end else begin
      divCnt <= divNext;
      bitClk <= (divNext >= DIV_HALF);
    end
  end

  // Index of the bit driven at the next fall; frame clock marks the last one.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdx   <= '0;
      frameClk <= 1'b0;
    end else if (fallNow) begin
      bitIdx   <= (bitIdx == IDX_LAST) ? '0 : bitIdx + IDX_W'(1);
      frameClk <= (bitIdx == IDX_LAST);
    end
  end

  always_comb begin
    strb.fallTick   = fallNow;
    strb.frameStart = fallNow && (bitIdx == '0);
    strb.frameEnd   = fallNow && (bitIdx == IDX_LAST);
  end

endmodule

// File: rtl/dfl_dpath.sv
module dfl_dpath
  import dfl_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dflStrobe_t        strb,
  input  logic [STAT_W-1:0] txStatus,
  input  logic [DATA_W-1:0] txData,
  input  logic              serIn,
  output logic              serOut,
  output logic [STAT_W-1:0] rxStatus,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  localparam int FRAME_BITS = STAT_W + DATA_W;
  localparam int MSB        = FRAME_BITS - 1;

  logic [MSB:0] txWord;
  logic [MSB:0] txShift;
  logic [MSB:0] rxShift;
  logic [MSB:0] rxNext;

  assign txWord = {txStatus, txData};
  assign rxNext = {rxShift[MSB-1:0], serIn};

  // Transmit: capture at frame start, then one bit per falling bit clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      serOut  <= 1'b0;
    end else if (strb.frameStart) begin
      serOut  <= txWord[MSB];
      txShift <= txWord << 1;
    end else if (strb.fallTick) begin
      serOut  <= txShift[MSB];
      txShift <= txShift << 1;
    end
  end

  // Receive: shift at every falling bit clock, hand off on the last bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift  <= '0;
      rxStatus <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= strb.frameEnd;
      if (strb.fallTick) rxShift <= rxNext;
      if (strb.frameEnd) begin
        rxStatus <= rxNext[MSB -: STAT_W];
        rxData   <= rxNext[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/duplex_frame_link.sv
module duplex_frame_link
  import dfl_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int DATA_W  = 8,
  parameter int BIT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] txStatus,
  input  logic [DATA_W-1:0] txData,
  input  logic              serIn,
  output logic              bitClk,
  output logic              frameClk,
  output logic              serOut,
  output logic [STAT_W-1:0] rxStatus,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  localparam int FRAME_BITS = STAT_W + DATA_W;

  dflStrobe_t strb;

  dfl_ctrl #(
    .BIT_DIV   (BIT_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bitClk  (bitClk),
    .frameClk(frameClk),
    .strb    (strb)
  );

  dfl_dpath #(
    .STAT_W(STAT_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .txStatus(txStatus),
    .txData  (txData),
    .serIn   (serIn),
    .serOut  (serOut),
    .rxStatus(rxStatus),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: rtl/duplex_frame_link_chk.sv
module duplex_frame_link_chk #(
  parameter int STAT_W  = 8,
  parameter int DATA_W  = 8,
  parameter int BIT_DIV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bitClk,
  input logic              frameClk,
  input logic              serOut,
  input logic [STAT_W-1:0] rxStatus,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid
);

  localparam int CNT_W = $clog2(BIT_DIV + 1) + 1;

  logic             rstQ;
  logic [CNT_W-1:0] hiCnt;

  // R1: outputs quiet one edge after reset was seen.
  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      assert_reset_quiet_R1: assert (!bitClk && !frameClk && !serOut && !rxValid &&
                                     rxStatus == '0 && rxData == '0)
        else $error("reset outputs not quiet");
    end
  end

  // Length of the current frame-clock high phase.
  always_ff @(posedge clk) begin
    if (rst)           hiCnt <= '0;
    else if (frameClk) hiCnt <= hiCnt + CNT_W'(1);
    else               hiCnt <= '0;
  end

  assert_bitclk_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bitClk) |=> $stable(bitClk));

  assert_bitclk_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bitClk) |=> $stable(bitClk));

  assert_frame_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(frameClk) |-> $fell(bitClk));

  assert_frame_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(frameClk) |-> (hiCnt == CNT_W'(BIT_DIV)));

  assert_ser_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(serOut) |-> $fell(bitClk));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rxValid |-> ($stable(rxStatus) && $stable(rxData)));

endmodule

bind duplex_frame_link duplex_frame_link_chk #(
  .STAT_W (STAT_W),
  .DATA_W (DATA_W),
  .BIT_DIV(BIT_DIV)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bitClk  (bitClk),
  .frameClk(frameClk),
  .serOut  (serOut),
  .rxStatus(rxStatus),
  .rxData  (rxData),
  .rxValid (rxValid)
);

// File: tb/duplex_frame_link_tb.sv
module duplex_frame_link_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 12;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] txStatus;
  logic [7:0] txData;
  logic       serIn;
  logic       bitClk, frameClk, serOut, rxValid;
  logic [7:0] rxStatus, rxData;

  int errors = 0;
  int checks = 0;
  int txSeen = 0;
  int rxSeen = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  logic [15:0] txExpQ[$];
  logic [15:0] rxExpQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  duplex_frame_link u_dut (
    .clk(clk), .rst(rst), .txStatus(txStatus), .txData(txData), .serIn(serIn),
    .bitClk(bitClk), .frameClk(frameClk), .serOut(serOut),
    .rxStatus(rxStatus), .rxData(rxData), .rxValid(rxValid)
  );

  function automatic logic [15:0] vecTx(int f);
    case (f % NF)
      0:  return 16'hA5C3;
      1:  return 16'h0000;
      2:  return 16'hFFFF;
      3:  return 16'h8001;
      4:  return 16'h7FFE;
      5:  return 16'h5AA5;
      6:  return 16'h0180;
      7:  return 16'hC33C;
      8:  return 16'h1234;
      9:  return 16'hFE01;
      10: return 16'h00FF;
      default: return 16'hFF00;
    endcase
  endfunction

  function automatic logic [15:0] vecRx(int f);
    logic [15:0] w;
    w = vecTx(f + 5);
    return {w[7:0], w[15:8]} ^ 16'(f % NF);
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic driveTx(logic [15:0] w);
    txStatus = w[15:8];
    txData   = w[7:0];
    txExpQ.push_back(w);
  endtask

  // Main: reset state, release, wait for completion.
  initial begin
    rst = 1'b1;
    driveTx(vecTx(0));
    serIn = vecRx(0)[15];
    rxExpQ.push_back(vecRx(0));
    repeat (3) @(posedge clk);
    txStatus = 8'h3C;  // inputs moving during reset must not disturb outputs (R1)
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!bitClk && !frameClk && !serOut && !rxValid, "R1 reset strobes",
          {12'h0, bitClk, frameClk, serOut, rxValid}, 16'h0);
    check(rxStatus == 8'h0 && rxData == 8'h0, "R1 reset rx", {rxStatus, rxData}, 16'h0);
    txStatus = vecTx(0)[15:8];
    rst = 1'b0;
    running = 1'b1;
    wait (txSeen >= NF && rxSeen >= NF);
    repeat (4) @(negedge clk);
    summary();
  end

  // Driver: words written in the last bit period before their frame (R4),
  // or in the middle of the previous frame (R5).
  initial begin
    wait (running);
    for (int f = 1; f < NF; f++) begin
      if (f % 3 == 0) begin
        repeat (6) @(posedge bitClk);
        driveTx(vecTx(f));  // R5: mid-frame write, current frame keeps old word
        @(posedge frameClk);
        @(negedge clk);
      end else begin
        @(posedge frameClk);
        @(negedge clk);
        driveTx(vecTx(f));
      end
    end
  end

  // Far-end model: samples serOut and updates serIn on rising bit clock.
  initial begin
    logic [15:0] word;
    int bitsIn;
    int farFrame;
    int pos;
    logic [15:0] exp;
    string tag;
    word = '0; bitsIn = 0; farFrame = 0; pos = 0;
    wait (running);
    @(negedge bitClk);
    forever begin
      @(posedge bitClk);
      word = {word[14:0], serOut};
      bitsIn++;
      if (frameClk) begin
        check(bitsIn == 16, "R3 bits per frame", 16'(bitsIn), 16'd16);
        if (txSeen < NF) begin
          exp = (txExpQ.size() > 0) ? txExpQ.pop_front() : 16'hxxxx;
          if (txSeen == 0)          tag = "R8 first tx frame";
          else if (txSeen % 3 == 0) tag = "R5 tx word";
          else                      tag = "R4 tx word";
          check(word === exp, tag, word, exp);
          if (txSeen % 3 == 2 && txExpQ.size() > 0)
            check(txExpQ[0] === vecTx(txSeen + 1), "R5 pending word", txExpQ[0], vecTx(txSeen + 1));
          txSeen++;
        end
        bitsIn = 0;
        farFrame++;
        pos = 0;
        rxExpQ.push_back(vecRx(farFrame));
      end else begin
        if (bitsIn >= 16) begin
          check(1'b0, "R3 missing frame strobe", 16'(bitsIn), 16'd15);
          bitsIn = 0;
        end
        pos++;
      end
      serIn = vecRx(farFrame)[15 - pos];
    end
  end

  // Receive monitor: scoreboard for rxStatus/rxData, pulse width and hold.
  initial begin
    logic prevValid;
    logic [15:0] held;
    logic [15:0] exp;
    prevValid = 1'b0;
    held = '0;
    wait (running);
    forever begin
      @(negedge clk);
      if (rxValid) begin
        check(!prevValid, "R7 pulse width", {15'h0, prevValid}, 16'h0);
        exp = (rxExpQ.size() > 0) ? rxExpQ.pop_front() : 16'hxxxx;
        if (rxSeen < NF) check({rxStatus, rxData} === exp, "R6 rx pair", {rxStatus, rxData}, exp);
        held = {rxStatus, rxData};
        rxSeen++;
      end else begin
        if (prevValid)
          check(!rxValid, "R7 pulse ends", {15'h0, rxValid}, 16'h0);
        if ({rxStatus, rxData} !== held)
          check(1'b0, "R7 rx hold", {rxStatus, rxData}, held);
      end
      prevValid = rxValid;
    end
  end

  // Edge timing monitor in system cycles.
  initial begin
    int cyc;
    int lastRise;
    int hiLen;
    int frLen;
    int lastFrRise;
    int bitChecks;
    bit seenFall;
    logic prevB, prevF, prevS;
    cyc = 0; lastRise = -1; hiLen = 0; frLen = 0; lastFrRise = -1; bitChecks = 0;
    seenFall = 1'b0;
    prevB = 1'b0; prevF = 1'b0; prevS = 1'b0;
    wait (running);
    forever begin
      @(negedge clk);
      cyc++;
      if (!seenFall && !(prevB && !bitClk))
        if (serOut) check(1'b0, "R8 early serOut", {15'h0, serOut}, 16'h0);
      if (lastRise < 0 && bitClk && !prevB)
        check(cyc == 2, "R2 first rise", 16'(cyc), 16'd2);
      if (bitClk && !prevB) begin
        if (lastRise >= 0 && bitChecks < 40) begin
          check(cyc - lastRise == 4, "R2 bit period", 16'(cyc - lastRise), 16'd4);
          bitChecks++;
        end
        lastRise = cyc;
      end
      if (bitClk) hiLen++;
      if (!bitClk && prevB) begin
        if (bitChecks < 40) check(hiLen == 2, "R2 bit high time", 16'(hiLen), 16'd2);
        hiLen = 0;
        seenFall = 1'b1;
      end
      if (serOut !== prevS)
        check(prevB && !bitClk, "R4 serOut on fall", {14'h0, prevB, bitClk}, 16'h2);
      if (frameClk && !prevF) begin
        check(prevB && !bitClk, "R3 frame on fall", {14'h0, prevB, bitClk}, 16'h2);
        if (lastFrRise >= 0)
          check(cyc - lastFrRise == 64, "R3 frame spacing", 16'(cyc - lastFrRise), 16'd64);
        lastFrRise = cyc;
      end
      if (frameClk) frLen++;
      if (!frameClk && prevF) begin
        check(frLen == 4, "R3 frame high time", 16'(frLen), 16'd4);
        frLen = 0;
      end
      prevB = bitClk;
      prevF = frameClk;
      prevS = serOut;
    end
  end

  // Watchdog.
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d frames", rxSeen, NF);
    summary();
  end

endmodule